// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Read Port

This block sits on the read side of a 36-bit FIFO and gives the data out on a narrower port. The port width is set by a static two-bit select: full long word (36 bits), half word (18 bits) or lane (9 bits). In the narrow widths, each long word taken from the FIFO is handed out as two halves or four lanes, one per accepted read. The block takes the next long word from the FIFO only after the last piece of the current one has been read.

The order of the pieces is fixed by a select input. Its value is captured once, on the first clock edge after reset is released. High gives most-significant-first (big-endian) and low gives least-significant-first (little-endian). In long-word width the order has no effect.

The FIFO is expected to show its head word on `fifo_data_i` whenever `fifo_empty_i` is low. A high `fifo_rd_o` at a clock edge pops that word.

Top module: `bus_match_rd_port`

## Requirements
- R1: `width_sel_i` 2'b00 or 2'b11 selects long-word width. `data_o` then carries the whole 36-bit word, and each accepted read pops the next word when the FIFO is not empty.
- R2: `width_sel_i` 2'b01 selects half-word width. Each long word is delivered as two 18-bit pieces on `data_o[17:0]`, with `data_o[35:18]` zero.
- R3: `width_sel_i` 2'b10 selects lane width. Each long word is delivered as four 9-bit pieces on `data_o[8:0]`, with `data_o[35:9]` zero.
- R4: With the captured order high, pieces are delivered from the most significant one (bits 35:27 or 35:18) down to the least significant one.
- R5: With the captured order low, pieces are delivered from the least significant one (bits 8:0 or 17:0) up to the most significant one.
- R6: `order_sel_i` is sampled on the first rising clock edge at which `rst_ni` is high. Later changes to it have no effect until the next reset.
- R7: In long-word width, the full word is delivered unchanged for either captured order.
- R8: `fifo_rd_o` is high only when the FIFO is not empty and either no word is held or the last piece of the held word is being read. It is low during reset and on the first edge after reset.
- R9: `empty_o` is high during reset and whenever no pieces remain and the FIFO is empty. Once a word is available and none is held, `empty_o` falls one clock later.
- R10: While `empty_o` is low and `rd_i` is low, `data_o` and `empty_o` stay unchanged.
- R11: Reset clears the piece counter and discards any partly delivered long word. After reset, the next piece out is the first piece of the next FIFO word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| width_sel_i | input | 2 | Port width: 00/11 long, 01 half, 10 lane (static) |
| order_sel_i | input | 1 | Piece order, captured after reset: 1 MS first, 0 LS first |
| fifo_data_i | input | 36 | Head word of the FIFO |
| fifo_empty_i | input | 1 | FIFO has no word |
| fifo_rd_o | output | 1 | Pop the FIFO head at this edge |
| rd_i | input | 1 | Read request on the narrow port |
| data_o | output | 36 | Current piece, zero-extended |
| empty_o | output | 1 | No piece available |

## Verification
Several properties are checked on every cycle. The FIFO is never popped while it is empty or while a held piece is left unread. Output stays still while no read is made. A waiting word fills the empty port after one clock. In long width each read pops a word. Lane width keeps the upper bits zero. The captured order never moves after capture. The actual order of pieces, the discarding of a partly read word on reset, and the fact that the order input is ignored after capture and in long width are shown only by the bench. It sweeps every width against both orders and compares each piece with a value it computes from the word index.

// File: rtl/brp_pkg.sv
package brp_pkg;
  typedef enum logic [1:0] {
    WM_LONG = 2'b00,
    WM_HALF = 2'b01,
    WM_LANE = 2'b10
  } width_mode_e;
endpackage

// File: rtl/brp_order_latch.sv
module brp_order_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic order_sel_i,
  output logic armed_o,
  output logic order_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      order_o <= 1'b0;
    end else if (!armed_o) begin
      armed_o <= 1'b1;
      order_o <= order_sel_i;
    end
  end
endmodule

// File: rtl/brp_piece_ctr.sv
module brp_piece_ctr
  import brp_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  width_mode_e   mode_i,
  input  logic          adv_i,
  output logic [CW-1:0] piece_o,
  output logic          last_o
);
  logic [CW-1:0] last_idx;

  always_comb begin
    unique case (mode_i)
      WM_HALF: last_idx = CW'(1);
      WM_LANE: last_idx = CW'(LANES - 1);
      default: last_idx = '0;
    endcase
  end

  assign last_o = (piece_o == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     piece_o <= '0;
    else if (adv_i)  piece_o <= last_o ? '0 : piece_o + CW'(1);
  end
endmodule

// File: rtl/brp_lane_mux.sv
module brp_lane_mux
  import brp_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES,
  localparam int HALF_W = WORD_W / 2,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  width_mode_e       mode_i,
  input  logic              order_i,
  input  logic [CW-1:0]     piece_i,
  output logic [WORD_W-1:0] data_o
);
  logic [LANE_W-1:0] lanes [LANES];
  logic [HALF_W-1:0] halves [2];
  logic [CW-1:0]     lane_idx;
  logic              half_idx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[g*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halves[h] = word_i[h*HALF_W +: HALF_W];
  end

  // big-endian walks from the top piece down
  assign lane_idx = order_i ? CW'(LANES - 1) - piece_i : piece_i;
  assign half_idx = order_i ? ~piece_i[0] : piece_i[0];

  always_comb begin
    data_o = '0;
    unique case (mode_i)
      WM_HALF: data_o[HALF_W-1:0] = halves[half_idx];
      WM_LANE: data_o[LANE_W-1:0] = lanes[lane_idx];
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/bus_match_rd_port.sv
module bus_match_rd_port
  import brp_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        width_sel_i,
  input  logic              order_sel_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_rd_o,
  input  logic              rd_i,
  output logic [WORD_W-1:0] data_o,
  output logic              empty_o
);
  width_mode_e       mode;
  logic              armed_q, order_q;
  logic              loaded_q, rd_acc, last;
  logic [CW-1:0]     piece;
  logic [WORD_W-1:0] word_q;

  assign mode = (width_sel_i == 2'b11) ? WM_LONG : width_mode_e'(width_sel_i);

  brp_order_latch u_order (
    .clk_i, .rst_ni, .order_sel_i,
    .armed_o(armed_q), .order_o(order_q)
  );

  brp_piece_ctr #(.LANES(LANES)) u_ctr (
    .clk_i, .rst_ni, .mode_i(mode), .adv_i(rd_acc),
    .piece_o(piece), .last_o(last)
  );

  brp_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
    .word_i(word_q), .mode_i(mode), .order_i(order_q),
    .piece_i(piece), .data_o(data_o)
  );

  assign rd_acc    = rd_i && loaded_q;
  assign fifo_rd_o = armed_q && !fifo_empty_i && (!loaded_q || (rd_acc && last));
  assign empty_o   = !loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      word_q   <= '0;
    end else if (fifo_rd_o) begin
      loaded_q <= 1'b1;
      word_q   <= fifo_data_i;
    end else if (rd_acc && last) begin
      loaded_q <= 1'b0;
    end
  end
endmodule

// File: rtl/brp_checker.sv
module brp_checker
  import brp_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int WORD_W = LANE_W * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input width_mode_e       mode,
  input logic              armed_q,
  input logic              order_q,
  input logic              fifo_empty_i,
  input logic              fifo_rd_o,
  input logic              rd_i,
  input logic [WORD_W-1:0] data_o,
  input logic              empty_o
);
  AST_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i); // R8
  AST_NO_POP_WHILE_HOLDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !rd_i) |-> !fifo_rd_o); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !rd_i) |=> (!empty_o && $stable(data_o))); // R10
  AST_FILL_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && empty_o && !fifo_empty_i) |=> !empty_o); // R9
  AST_ORDER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(armed_q)) |-> $stable(order_q)); // R6
  AST_LONG_POP_EACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WM_LONG && rd_i && !empty_o && !fifo_empty_i) |-> fifo_rd_o); // R1
  AST_LANE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WM_LANE && !empty_o) |-> (data_o[WORD_W-1:LANE_W] == '0)); // R3
endmodule

bind bus_match_rd_port brp_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode(mode), .armed_q(armed_q),
  .order_q(order_q), .fifo_empty_i(fifo_empty_i), .fifo_rd_o(fifo_rd_o),
  .rd_i(rd_i), .data_o(data_o), .empty_o(empty_o)
);

// File: tb/sim_bus_match_rd_port.sv
module sim_bus_match_rd_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  width_sel = 2'b00;
  logic        order_sel = 1'b0;
  logic [35:0] fifo_data;
  logic        fifo_empty, fifo_rd;
  logic        rd = 1'b0;
  logic [35:0] data;
  logic        empty;
  int          rd_p = 0, wr_p = 0, exp_idx = 0;
  int          errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [35:0] word_of(int i);
    return {9'(i*37 + 5), 9'(i*11 + 200), 9'(i*3 + 77), 9'(i*29 + 1)};
  endfunction

  function automatic logic [35:0] exp_piece(logic [35:0] w, logic [1:0] m, logic o, int k);
    int idx;
    if (m == 2'b01) begin
      idx = o ? 1 - k : k;
      return {18'd0, w[idx*18 +: 18]};
    end else if (m == 2'b10) begin
      idx = o ? 3 - k : k;
      return {27'd0, w[idx*9 +: 9]};
    end
    return w;
  endfunction

  // FIFO model: head is computed from the read index
  assign fifo_data  = word_of(rd_p);
  assign fifo_empty = (rd_p == wr_p);
  always @(posedge clk) if (fifo_rd) rd_p <= rd_p + 1;

  bus_match_rd_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .width_sel_i(width_sel), .order_sel_i(order_sel),
    .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty), .fifo_rd_o(fifo_rd),
    .rd_i(rd), .data_o(data), .empty_o(empty)
  );

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  // reset with a chosen order, then flip the input to show it is ignored (R6)
  task automatic do_reset(logic [1:0] m, logic o);
    @(negedge clk);
    rd = 1'b0; rst_n = 1'b0; width_sel = m; order_sel = o;
    repeat (2) @(negedge clk);
    chk(empty == 1'b1, "R9 reset empty", 36'(empty), 36'd1);
    chk(fifo_rd == 1'b0, "R8 no pop in reset", 36'(fifo_rd), 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    order_sel = ~o;
  endtask

  task automatic push(int n);
    @(negedge clk);
    wr_p += n;
  endtask

  task automatic drain_words(logic [1:0] m, logic o, int n, string req);
    int np = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
    rd = 1'b0;
    @(negedge clk);
    while (empty) @(negedge clk);
    for (int w = 0; w < n; w++) begin
      for (int k = 0; k < np; k++) begin
        chk(!empty && data == exp_piece(word_of(exp_idx), m, o, k), req,
            data, exp_piece(word_of(exp_idx), m, o, k));
        rd = 1'b1;
        @(negedge clk);
      end
      exp_idx++;
    end
    rd = 1'b0;
  endtask

  initial begin
    logic [35:0] held;
    int pops;
    for (int mi = 0; mi < 3; mi++) begin
      for (int oi = 0; oi < 2; oi++) begin
        logic [1:0] m = (mi == 0) ? 2'b00 : (mi == 1) ? 2'b01 : 2'b10;
        string req = (mi == 0) ? "R1 R7 long" : (mi == 1) ? (oi ? "R2 R4 half" : "R2 R5 half")
                                                          : (oi ? "R3 R4 lane" : "R3 R5 lane");
        do_reset(m, oi[0]);
        push(5);
        drain_words(m, oi[0], 5, req);
        chk(empty == 1'b1, "R9 empty after drain", 36'(empty), 36'd1);
        chk(rd_p == wr_p, "R8 pop count", 36'(rd_p), 36'(wr_p));
      end
    end

    // encoding 11 behaves as long width (R1)
    do_reset(2'b11, 1'b1);
    push(2);
    drain_words(2'b00, 1'b1, 2, "R1 code 11");

    // fill latency (R9)
    do_reset(2'b00, 1'b0);
    repeat (2) @(negedge clk);
    wr_p += 1;
    chk(empty == 1'b1, "R9 still empty at push", 36'(empty), 36'd1);
    @(negedge clk);
    chk(empty == 1'b0, "R9 filled next clock", 36'(empty), 36'd0);
    drain_words(2'b00, 1'b0, 1, "R9 data");

    // hold without reads (R10, R8)
    do_reset(2'b10, 1'b1);
    push(2);
    @(negedge clk);
    @(negedge clk);
    held = data;
    pops = rd_p;
    repeat (3) @(negedge clk);
    chk(data == held && !empty, "R10 hold", data, held);
    chk(held == exp_piece(word_of(exp_idx), 2'b10, 1'b1, 0), "R10 first piece",
        held, exp_piece(word_of(exp_idx), 2'b10, 1'b1, 0));
    chk(rd_p == pops, "R8 no pop while holding", 36'(rd_p), 36'(pops));
    drain_words(2'b10, 1'b1, 2, "R10 R4 after hold");

    // reset mid-word discards the remainder (R11)
    do_reset(2'b10, 1'b0);
    push(2);
    @(negedge clk);
    @(negedge clk);
    rd = 1'b1;
    repeat (2) @(negedge clk);
    rd = 1'b0;
    chk(data == exp_piece(word_of(exp_idx), 2'b10, 1'b0, 2), "R11 partial read",
        data, exp_piece(word_of(exp_idx), 2'b10, 1'b0, 2));
    exp_idx++;
    do_reset(2'b10, 1'b1);
    drain_words(2'b10, 1'b1, 1, "R11 R6 after reset");
    chk(empty == 1'b1, "R11 empty", 36'(empty), 36'd1);

    summary();
  end
endmodule